// File: doc/BRIEF.md
# Multi-Character Transition Detector

This block runs a reduced non-deterministic automaton over a byte stream. A state can advance by consuming a whole string of up to `P` characters in one transition, so the automaton needs fewer states than one that moves a single character at a time. The string detector looks at the current input byte and the `P-1` bytes before it. Each byte position indexes its own small loadable table, and each table holds one bit per transition string. The bitwise AND of the `P` table outputs gives one detect bit per string.

Each matching state keeps a short record of its recent activity, one bit per consumed character. A transition whose string is `k` characters long reads its source state's activity from `k` characters earlier, and combines it with the detect bit of the string that has just completed.

The default build uses `P = 3` with three strings and the automaton for `abc(ab)*a`. State 0 is the start state and is always active, so a match can begin at any character. State 1 is entered by `abc` from start and by `ab` from itself. State 2, the accepting state, is entered by `a` from state 1. The tables are written through a byte-addressed write port before or between streams.

Top module: `mct_detector`

## Requirements
- R1: After reset, `matchHit` is 0, `strDetect` is 0, and the character history is empty. A string longer than one character cannot be detected until all of its characters have arrived after reset.
- R2: A character is consumed only in a cycle with `charValid` high, and one character is consumed per such cycle. Idle cycles between characters change neither the history nor the state activity.
- R3: `strDetect[s]` is high in a cycle with `charValid` high exactly when the AND over every position j of table j's bit s is 1. Table j is addressed by the byte j characters back, where position 0 is `charIn` itself.
- R4: Setting bit s to 1 at all 256 addresses of table j marks position j as don't-care for string s. A one-character string `a` is then detected after any predecessor, or with no predecessor at all.
- R5: A character presented with `streamStart` high begins a new stream. No earlier byte takes part in any detection, and every non-start state loses its earlier activity.
- R6: A write with `memWrEn` high stores `memWrData` (bit s for string s) at address `memWrAddr` of table `memWrPos`. Detection uses the new contents from the next character on.
- R7: A state entered by a k-character string becomes active on the character that completes the string, only if its source state was active k characters earlier. The default build gives `abc` → bit 0, `ab` → bit 1, `a` → bit 2.
- R8: A state may re-enter itself through a multi-character string. In the default build, state 1 stays reachable across any number of repeated `ab`.
- R9: `matchHit` is high for exactly the one clock cycle that follows the edge at which the accepting state is entered, and low otherwise.
- R10: The start state is always active, so a match can begin at any character of a stream, including after failed partial matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| charValid | input | 1 | A character is presented this cycle |
| streamStart | input | 1 | The presented character is the first of a new stream |
| charIn | input | 8 | Input character |
| memWrEn | input | 1 | Write one table entry |
| memWrPos | input | PW (2) | Table to write, 0 = current character |
| memWrAddr | input | 8 | Byte address within the table |
| memWrData | input | NSTR (3) | One bit per string |
| strDetect | output | NSTR (3) | Per-string detect for the presented character |
| matchHit | output | 1 | One-cycle pulse when the accepting state is entered |

## Verification
The bench builds the block with `P = 3`, three strings of lengths 3, 2 and 1, and the three-state automaton of `abc(ab)*a`. With these values one run covers a full-width string whose three positions all matter, a string with one don't-care position, and a string with two. It also covers a self-loop through a two-character string and an accepting transition that reads the activity of the previous character. A stream restart that falls inside a partial string is tested, and so is a table rewrite that moves the accepting character.

// File: rtl/mct_pkg.sv
package mct_pkg;

  // Strobes issued by the control to the datapath and state logic
  typedef struct packed {
    logic shift;  // consume the presented character
    logic clear;  // the presented character opens a new stream
    logic wr;     // write one detector table entry
  } mctStrobe_t;

endpackage

// File: rtl/mct_ctrl.sv
module mct_ctrl
  import mct_pkg::*;
(
  input  logic       charValid,
  input  logic       streamStart,
  input  logic       memWrEn,
  output mctStrobe_t strb
);

  always_comb begin
    strb.shift = charValid;
    strb.clear = charValid & streamStart;
    strb.wr    = memWrEn;
  end

endmodule

// File: rtl/mct_fimm.sv
module mct_fimm
  import mct_pkg::*;
#(
  parameter int P       = 3,
  parameter int NSTR    = 3,
  parameter int STR_LEN [NSTR] = '{3, 2, 1},
  localparam int PW     = (P > 1) ? $clog2(P) : 1,
  localparam int HD     = (P > 1) ? P - 1 : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  mctStrobe_t      strb,
  input  logic [7:0]      charIn,
  input  logic [PW-1:0]   wrPos,
  input  logic [7:0]      wrAddr,
  input  logic [NSTR-1:0] wrData,
  output logic [NSTR-1:0] detect
);

  logic [7:0]      hist [HD];   // hist[i]: byte i+1 characters back
  logic [HD-1:0]   histV;
  logic [NSTR-1:0] posHit [P];
  logic [NSTR-1:0] longMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      histV <= '0;
      for (int i = 0; i < HD; i++) hist[i] <= '0;
    end else if (strb.shift) begin
      hist[0]  <= charIn;
      histV[0] <= 1'b1;
      for (int i = 1; i < HD; i++) begin
        hist[i]  <= hist[i-1];
        histV[i] <= histV[i-1] & ~strb.clear;
      end
    end
  end

  for (genvar p = 0; p < P; p++) begin : gPos
    logic [NSTR-1:0] mem [256];
    logic [NSTR-1:0] care;

    always_ff @(posedge clk) begin
      if (strb.wr && wrPos == PW'(p)) mem[wrAddr] <= wrData;
    end

    always_comb begin
      for (int s = 0; s < NSTR; s++) care[s] = (STR_LEN[s] > p);
    end

    if (p == 0) begin : gNow
      assign posHit[p] = mem[charIn];
    end else begin : gOld
      // an empty slot satisfies only the strings that ignore it
      assign posHit[p] = (histV[p-1] && !strb.clear) ? mem[hist[p-1]] : ~care;
    end
  end

  always_comb begin
    logic [NSTR-1:0] acc;
    acc = '1;
    for (int p = 0; p < P; p++) acc &= posHit[p];
    detect = strb.shift ? acc : '0;
    for (int s = 0; s < NSTR; s++) longMask[s] = (STR_LEN[s] > 1);
  end

  // R2
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> $stable(histV) && $stable(hist[0]));

  // R5
  clear_long_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |-> ((detect & longMask) == '0));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |-> detect == '0);

endmodule

// File: rtl/mct_states.sv
module mct_states
  import mct_pkg::*;
#(
  parameter int P       = 3,
  parameter int NSTR    = 3,
  parameter int NSTATE  = 3,
  parameter int NTRANS  = 3,
  parameter int STR_LEN [NSTR]   = '{3, 2, 1},
  parameter int TR_SRC  [NTRANS] = '{0, 1, 1},
  parameter int TR_DST  [NTRANS] = '{1, 1, 2},
  parameter int TR_STR  [NTRANS] = '{0, 1, 2},
  parameter int ACCEPT  = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  mctStrobe_t      strb,
  input  logic [NSTR-1:0] detect,
  output logic            matchHit
);

  // actLine[s][i]: state s was active i+1 characters ago
  logic [P-1:0]      actLine [NSTATE];
  logic [NTRANS-1:0] transHit;
  logic [NSTATE-1:0] nextAct;

  for (genvar t = 0; t < NTRANS; t++) begin : gTr
    localparam int SRC = TR_SRC[t];
    localparam int SI  = TR_STR[t];
    localparam int LAG = STR_LEN[TR_STR[t]] - 1;
    if (SRC == 0) begin : gFromStart
      assign transHit[t] = detect[SI];
    end else begin : gFromState
      assign transHit[t] = detect[SI] & ~strb.clear & actLine[SRC][LAG];
    end
  end

  always_comb begin
    nextAct    = '0;
    nextAct[0] = 1'b1;
    for (int d = 1; d < NSTATE; d++) begin
      for (int t = 0; t < NTRANS; t++) begin
        if (TR_DST[t] == d && transHit[t]) nextAct[d] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NSTATE; s++) actLine[s] <= '0;
      matchHit <= 1'b0;
    end else begin
      matchHit <= strb.shift & nextAct[ACCEPT];
      if (strb.shift) begin
        for (int s = 0; s < NSTATE; s++) begin
          actLine[s] <= strb.clear ? P'(nextAct[s])
                                   : ((actLine[s] << 1) | P'(nextAct[s]));
        end
      end
    end
  end

  // R9
  match_after_char_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |-> $past(strb.shift));

  // R9
  match_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |-> actLine[ACCEPT][0]);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> $stable(actLine[ACCEPT]) && !matchHit);

endmodule

// File: rtl/mct_detector.sv
module mct_detector
  import mct_pkg::*;
#(
  parameter int P       = 3,
  parameter int NSTR    = 3,
  parameter int NSTATE  = 3,
  parameter int NTRANS  = 3,
  parameter int STR_LEN [NSTR]   = '{3, 2, 1},
  parameter int TR_SRC  [NTRANS] = '{0, 1, 1},
  parameter int TR_DST  [NTRANS] = '{1, 1, 2},
  parameter int TR_STR  [NTRANS] = '{0, 1, 2},
  parameter int ACCEPT  = 2,
  localparam int PW     = (P > 1) ? $clog2(P) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            charValid,
  input  logic            streamStart,
  input  logic [7:0]      charIn,
  input  logic            memWrEn,
  input  logic [PW-1:0]   memWrPos,
  input  logic [7:0]      memWrAddr,
  input  logic [NSTR-1:0] memWrData,
  output logic [NSTR-1:0] strDetect,
  output logic            matchHit
);

  mctStrobe_t strb;

  mct_ctrl uCtrl (
    .charValid   (charValid),
    .streamStart (streamStart),
    .memWrEn     (memWrEn),
    .strb        (strb)
  );

  mct_fimm #(.P(P), .NSTR(NSTR), .STR_LEN(STR_LEN)) uFimm (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .charIn (charIn),
    .wrPos  (memWrPos),
    .wrAddr (memWrAddr),
    .wrData (memWrData),
    .detect (strDetect)
  );

  mct_states #(
    .P(P), .NSTR(NSTR), .NSTATE(NSTATE), .NTRANS(NTRANS),
    .STR_LEN(STR_LEN), .TR_SRC(TR_SRC), .TR_DST(TR_DST),
    .TR_STR(TR_STR), .ACCEPT(ACCEPT)
  ) uStates (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .detect   (strDetect),
    .matchHit (matchHit)
  );

endmodule

// File: tb/sim_mct_detector.sv
module sim_mct_detector;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic       rstN, charValid, streamStart, memWrEn, matchHit;
  logic [7:0] charIn, memWrAddr;
  logic [1:0] memWrPos;
  logic [2:0] memWrData, strDetect;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct packed { logic [2:0] det; logic mt; } exp_t;
  exp_t       expQ [$];
  string      tagQ [$];
  logic [7:0] hm [$];   // bench history, index 0 = newest
  logic       am [$];   // bench activity of state 1, index 0 = newest
  logic [7:0] s2ch;

  mct_detector u0 (
    .clk(clk), .rstN(rstN), .charValid(charValid), .streamStart(streamStart),
    .charIn(charIn), .memWrEn(memWrEn), .memWrPos(memWrPos),
    .memWrAddr(memWrAddr), .memWrData(memWrData),
    .strDetect(strDetect), .matchHit(matchHit)
  );

  // R6: table bit s is string s; table 0 holds the newest byte
  task automatic loadTables(input logic [7:0] accCh);
    s2ch = accCh;
    for (int p = 0; p < 3; p++) begin
      for (int a = 0; a < 256; a++) begin
        @(negedge clk);
        memWrEn   = 1'b1;
        memWrPos  = 2'(p);
        memWrAddr = 8'(a);
        case (p)
          0: memWrData = {8'(a) == accCh, 8'(a) == 8'h62, 8'(a) == 8'h63};
          1: memWrData = {1'b1, 8'(a) == 8'h61, 8'(a) == 8'h62};
          default: memWrData = {1'b1, 1'b1, 8'(a) == 8'h61};
        endcase
      end
    end
    @(negedge clk);
    memWrEn = 1'b0;
  endtask

  task automatic sendChar(input logic [7:0] c, input logic st, input string tag);
    logic d0, d1, d2, a1, a2, aNow;
    exp_t e;
    if (st) begin hm.delete(); am.delete(); end
    hm.push_front(c);
    if (hm.size() > 4) void'(hm.pop_back());
    d0 = hm.size() >= 3 && hm[0] == 8'h63 && hm[1] == 8'h62 && hm[2] == 8'h61;
    d1 = hm.size() >= 2 && hm[0] == 8'h62 && hm[1] == 8'h61;
    d2 = hm[0] == s2ch;
    a1 = (am.size() >= 1) ? am[0] : 1'b0;
    a2 = (am.size() >= 2) ? am[1] : 1'b0;
    aNow = d0 | (d1 & a2);
    am.push_front(aNow);
    if (am.size() > 4) void'(am.pop_back());
    e.det = {d2, d1, d0};
    e.mt  = d2 & a1;
    @(negedge clk);
    charValid   = 1'b1;
    streamStart = st;
    charIn      = c;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic sendStr(input string s, input logic st, input string tag);
    for (int i = 0; i < s.len(); i++) sendChar(s[i], st && i == 0, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      charValid   = 1'b0;
      streamStart = 1'b0;
    end
  endtask

  // monitor: scoreboard pop and compare
  initial begin
    logic pend;
    string pendTag;
    exp_t e;
    string t;
    pend = 1'b0;
    pendTag = "R9";
    forever begin
      @(negedge clk);
      #2;
      if (!rstN) begin
        pend = 1'b0;
      end else begin
        checks++;
        if (matchHit !== pend) begin
          fails++;
          $display("FAIL %s matchHit: actual %b expected %b", pendTag, matchHit, pend);
        end
        pend = 1'b0;
        pendTag = "R9";
        if (charValid) begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          checks++;
          if (strDetect !== e.det) begin
            fails++;
            $display("FAIL %s strDetect: actual %b expected %b", t, strDetect, e.det);
          end
          pend = e.mt;
          pendTag = t;
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; charValid = 1'b0; streamStart = 1'b0; charIn = '0;
    memWrEn = 1'b0; memWrPos = '0; memWrAddr = '0; memWrData = '0;
    s2ch = 8'h61;
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    checks++;
    if (matchHit !== 1'b0 || strDetect !== 3'b000) begin
      fails++;
      $display("FAIL R1 reset: actual %b/%b expected 0/000", matchHit, strDetect);
    end
    @(negedge clk);
    rstN = 1'b1;
    loadTables(8'h61);
    // R1: empty history after reset, 'bc' alone completes nothing long
    sendStr("bc", 1'b0, "R1");
    idle(2);
    // R3 R7 R9: basic match
    sendStr("abca", 1'b1, "R7");
    idle(2);
    // R8: self-loop through ab
    sendStr("abcababa", 1'b1, "R8");
    idle(2);
    // R10: failed partial then restart mid-stream
    sendStr("xxabcza", 1'b1, "R10");
    sendStr("yabca", 1'b0, "R10");
    idle(2);
    // R2: idle gaps between characters
    sendChar(8'h61, 1'b1, "R2"); idle(3);
    sendChar(8'h62, 1'b0, "R2"); idle(1);
    sendChar(8'h63, 1'b0, "R2"); idle(2);
    sendChar(8'h61, 1'b0, "R2"); idle(2);
    // R5: restart inside a string, and state loss
    sendStr("ab", 1'b1, "R5");
    sendStr("c", 1'b1, "R5");
    sendStr("abc", 1'b1, "R5");
    sendStr("a", 1'b1, "R5");
    idle(2);
    // R4: one-character string after any predecessor
    sendStr("qa", 1'b1, "R4");
    sendStr("za", 1'b0, "R4");
    idle(2);
    // R3: overlapping strings
    sendStr("aabcabca", 1'b1, "R3");
    idle(2);
    // R6: rewrite so the accepting character is x
    loadTables(8'h78);
    sendStr("abca", 1'b1, "R6");
    sendStr("abcx", 1'b1, "R6");
    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule